// File: doc/BRIEF.md
# Tick-Gated PWM Duty Generator

This block produces a pulse-width-modulated output from two configuration values: a frame length and an on-time. It does not count clock cycles. It counts tick pulses that some external rate generator supplies. Each output frame is made of (period + 1) ticks. The output is high for the first `on` ticks of the frame and low for the remaining ticks, so the duty fraction is on / (period + 1).

The configuration inputs pass through a shadow stage. New values take effect only where one frame ends and the next begins, or at any time while the channel is stopped. Changing them mid-frame therefore never produces a truncated or stretched pulse.

An on-time larger than the period gives a flat, fully-on output. An on-time of zero gives a flat, fully-off output. Clearing the run input parks the counter at the start of a frame and forces the output low.

Top module: `pwm_frame_gen`

## Requirements
- R1: While reset is asserted and until the first frame is started, `pwm_o` is 0. Reset is asynchronous, active-low, and released through a two-stage synchronizer.
- R2: While `run_i` is 1, the frame position advances by one on each clock with `tick_i` = 1. It returns to 0 on the tick after position `period`, so one frame spans period+1 ticks.
- R3: While running, `pwm_o` is 1 exactly when the frame position is below the active on-time. The output is therefore high for the first `on` ticks of each frame.
- R4: When the active on-time is greater than the active period (for example on=0xFF, period=0xFE, or on=period+1), `pwm_o` stays 1 for the whole time the channel runs.
- R5: When the active on-time is 0, `pwm_o` stays 0 for the whole time the channel runs.
- R6: Values on `period_i` and `on_i` are captured only on a tick that ends a frame, or on any clock while `run_i` is 0. A change made mid-frame first affects the following frame.
- R7: While `run_i` is 0, the frame position is held at 0 and `pwm_o` is 0. Setting `run_i` again starts a fresh frame at position 0.
- R8: While running, clocks with `tick_i` = 0 leave the frame position and `pwm_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Channel run enable; 0 parks the counter and drives the output low |
| tick_i | input | 1 | Time-base tick; one pulse advances the frame by one step |
| period_i | input | W (8) | Requested frame length minus one |
| on_i | input | W (8) | Requested number of high ticks per frame |
| pwm_o | output | 1 | Modulated output |

## Verification
The hardest case to reach is a configuration change that arrives part-way through a frame. Only the shape of the frames that follow shows whether the change was deferred. The bench loads one setting while the channel is stopped and starts it ticking. On the second tick of the frame it switches both inputs to a shorter, different pattern. It then compares the following seven tick positions against the tail of the old frame followed by two frames of the new one. Separate runs with ticks withheld, and with the run input dropped mid-frame, cover holding the frame position and restarting it.

// File: rtl/pwm_frame_pkg.sv
package pwm_frame_pkg;
  localparam int unsigned PWM_DEF_W = 8;

  typedef enum logic [1:0] {
    CNT_CLEAR = 2'd0,
    CNT_HOLD  = 2'd1,
    CNT_STEP  = 2'd2,
    CNT_WRAP  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow #(
  parameter int unsigned W = pwm_frame_pkg::PWM_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] on_i,
  output logic [W-1:0] per_q,
  output logic [W-1:0] on_q
);
  logic [W-1:0] per_d, on_d;

  always_comb begin
    per_d = per_q;
    on_d  = on_q;
    if (load) begin
      per_d = per_i;
      on_d  = on_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      on_q  <= '0;
    end else begin
      per_q <= per_d;
      on_q  <= on_d;
    end
  end

  a_r6_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (per_q == $past(per_q)) && (on_q == $past(on_q)));
endmodule

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr
  import pwm_frame_pkg::*;
#(
  parameter int unsigned W = PWM_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] per_q,
  output logic [W-1:0] cnt_q,
  output logic         frame_end
);
  cnt_op_e      op;
  logic [W-1:0] cnt_d;
  logic         at_last;

  assign at_last   = (cnt_q == per_q);
  assign frame_end = run && tick && at_last;

  always_comb begin
    if (!run)         op = CNT_CLEAR;
    else if (!tick)   op = CNT_HOLD;
    else if (at_last) op = CNT_WRAP;
    else              op = CNT_STEP;
  end

  always_comb begin
    unique case (op)
      CNT_CLEAR: cnt_d = '0;
      CNT_HOLD:  cnt_d = cnt_q;
      CNT_STEP:  cnt_d = cnt_q + 1'b1;
      CNT_WRAP:  cnt_d = '0;
      default:   cnt_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r2_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= per_q));
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt_q == $past(cnt_q)));
  a_r7_idle_parks: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int unsigned W = pwm_frame_pkg::PWM_DEF_W
) (
  input  logic         run,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] on_q,
  output logic         pwm
);
  // Non-modular compare: an on-time above the period can never be reached
  // by the counter, so the output stays high without a special case.
  assign pwm = run && (cnt_q < on_q);
endmodule

// File: rtl/pwm_frame_gen.sv
module pwm_frame_gen #(
  parameter int unsigned W = pwm_frame_pkg::PWM_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] on_i,
  output logic         pwm_o
);
  logic         rst_sync_n;
  logic [W-1:0] per_q, on_q, cnt_q;
  logic         frame_end, load, run_eff;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign run_eff = run_i && rst_sync_n;
  assign load    = !run_eff || frame_end;

  pwm_cfg_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_sync_n), .load(load),
    .per_i(period_i), .on_i(on_i), .per_q(per_q), .on_q(on_q)
  );

  pwm_frame_ctr #(.W(W)) u_ctr (
    .clk(clk), .rst_n(rst_sync_n), .run(run_eff), .tick(tick_i),
    .per_q(per_q), .cnt_q(cnt_q), .frame_end(frame_end)
  );

  pwm_duty_cmp #(.W(W)) u_cmp (
    .run(run_eff), .cnt_q(cnt_q), .on_q(on_q), .pwm(pwm_o)
  );

  a_r4_full_on: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_i && (on_q > per_q)) |-> pwm_o);
  a_r5_full_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_i && (on_q == '0)) |-> !pwm_o);
  a_r7_stopped_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_i |-> !pwm_o);
endmodule

// File: tb/pwm_frame_gen_bench.sv
module pwm_frame_gen_bench;
  localparam int W = 8;
  localparam int NV = 8;
  localparam logic [7:0] VP [NV] = '{8'd3, 8'd3, 8'd3, 8'd3, 8'hFE, 8'd0, 8'd7, 8'd9};
  localparam logic [7:0] VO [NV] = '{8'd1, 8'd2, 8'd0, 8'd4, 8'hFF, 8'd1, 8'd8, 8'd5};

  logic clk, rst_n, run_i, tick_i, pwm_o;
  logic [W-1:0] period_i, on_i;
  int checks, errors;
  bit done;

  pwm_frame_gen #(.W(W)) u_pwm_frame_gen (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(tick_i),
    .period_i(period_i), .on_i(on_i), .pwm_o(pwm_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", req, what, got, exp);
    end
  endtask

  task automatic load_idle(input logic [7:0] p, input logic [7:0] o);
    run_i = 1'b0; tick_i = 1'b0; period_i = p; on_i = o;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; run_i = 1'b1; tick_i = 1'b1; period_i = 8'd3; on_i = 8'd2;
    repeat (3) @(negedge clk);
    check("R1", pwm_o, 1'b0, "in reset");
    rst_n = 1'b1; run_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", pwm_o, 1'b0, "after release");

    // Vector table: two frames each, every tick position compared
    for (int v = 0; v < NV; v++) begin
      int len, bad, bad_k;
      logic bad_got, bad_exp;
      string tag;
      load_idle(VP[v], VO[v]);
      run_i = 1'b1; tick_i = 1'b1; #1;
      len = int'(VP[v]) + 1;
      bad = 0; bad_k = 0; bad_got = 1'b0; bad_exp = 1'b0;
      for (int k = 0; k < 2 * len; k++) begin
        logic e;
        e = ((k % len) < int'(VO[v]));
        if (pwm_o !== e && bad == 0) begin
          bad = 1; bad_k = k; bad_got = pwm_o; bad_exp = e;
        end
        @(negedge clk);
      end
      tag = (VO[v] == 0) ? "R5" : (VO[v] > VP[v]) ? "R4" : "R2/R3";
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL %s vec %0d tick %0d got %b exp %b", tag, v, bad_k, bad_got, bad_exp);
      end
    end

    // R8: no ticks, position held
    load_idle(8'd3, 8'd1);
    run_i = 1'b1; tick_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R8", pwm_o, 1'b1, "held at position 0");
    tick_i = 1'b1; @(negedge clk);
    tick_i = 1'b0;
    check("R8", pwm_o, 1'b0, "one tick to position 1");
    repeat (3) @(negedge clk);
    check("R8", pwm_o, 1'b0, "held at position 1");

    // R7: stop mid-frame, then restart
    run_i = 1'b0; #1;
    check("R7", pwm_o, 1'b0, "stopped low");
    @(negedge clk);
    run_i = 1'b1; tick_i = 1'b1; #1;
    check("R7", pwm_o, 1'b1, "restart at position 0");
    @(negedge clk);

    // R6: change mid-frame, takes effect next frame
    begin
      logic exp_seq [7] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      int bad;
      load_idle(8'd3, 8'd2);
      run_i = 1'b1; tick_i = 1'b1; #1;
      bad = 0;
      if (pwm_o !== 1'b1) bad = 1;
      @(negedge clk);
      period_i = 8'd1; on_i = 8'd1; #1;
      for (int k = 0; k < 7; k++) begin
        if (pwm_o !== exp_seq[k] && bad == 0) begin
          bad = 1;
          errors++;
          $display("FAIL R6 step %0d got %b exp %b", k, pwm_o, exp_seq[k]);
        end
        @(negedge clk);
      end
      checks++;
    end

    run_i = 1'b0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule